// File: doc/BRIEF.md
# Transactional Undo Log Controller

This block keeps the version state for the transactional stores of one processor using an undo log. Stores always update memory in place. The first store that a transaction makes to a line first saves the line's previous contents to a log held in ordinary memory. Each log entry is one address word followed by the whole old block. A small tracking array holds a read bit and a write bit per line. The write bit records that the line is already saved, so later stores to that line go straight through.

Committing the outermost transaction clears the bits and rewinds the log pointer to the log base, and no data moves. An abort walks the log from its newest entry down to its oldest and copies each saved block back to its line. It then clears the bits, rewinds the pointer and leaves the transaction.

Processor requests use a valid/ready handshake: a request is taken on a cycle where `req_valid` and `req_ready` are both high. The requester holds the request stable until it is taken. `req_ready` is low while the controller is busy with a logging sequence, a restore or a load response. Load data comes back on a one-cycle `rsp_valid` pulse, which cannot be back-pressured. The memory port is plain: it is always ready, a write takes effect at the clock edge, and read data is valid in the cycle after the read is issued.

Top module: `ulog_ctrl`

## Requirements
- R1: A request is taken when `req_valid` and `req_ready` are both high. `req_ready` is high exactly when `busy` is low. After reset both are idle: `req_ready`=1, `busy`=0, `rsp_valid`=0, `tx_depth`=0, `log_ptr`=LOG_BASE, and all read and write bits are 0.
- R2: A load (`req_op`=0) returns the memory word at `req_addr` on `rsp_valid` in the cycle after it is taken, and `req_ready` is low for exactly that one cycle. Inside a transaction, a load sets the read bit of its line, where the line is `req_addr[LW+OW-1:OW]`.
- R3: A store (`req_op`=1) inside a transaction to a line whose write bit is clear first writes a log entry at `log_ptr`. The entry holds the line's first word address, then the 8 old words in order. The store then writes the new word in place, sets the write bit and advances `log_ptr` by 9. `req_ready` stays low for 18 cycles.
- R4: A transactional store to a line whose write bit is already set writes in place in the cycle it is taken. It adds no log entry, and `log_ptr` is unchanged.
- R5: A store outside any transaction writes in place, sets no bit and writes no log entry.
- R6: Begin (`req_op`=2) raises `tx_depth` by one, saturating at its maximum. Commit (`req_op`=3) lowers it by one. Only the commit that reaches depth 0 clears all read and write bits and rewinds `log_ptr` to LOG_BASE, and it leaves memory data unchanged. At depth 0 every bit is clear and `log_ptr` equals LOG_BASE.
- R7: A commit at depth 0 has no effect.
- R8: An abort (`req_op`=4) inside a transaction restores every logged line to the value it held before its first transactional store. It then clears the bits, sets depth 0 and rewinds `log_ptr`. `req_ready` stays low for 17 cycles per log entry plus 1.
- R9: The restore writes the log entries back newest first, so the oldest entry is restored last.
- R10: An abort at depth 0, and any `req_op` value from 5 to 7, has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can take a request |
| req_op | input | 3 | 0 load, 1 store, 2 begin, 3 commit, 4 abort |
| req_addr | input | LW+OW (7) | Word address in the data region |
| req_wdata | input | DW (32) | Store data |
| rsp_valid | output | 1 | Load data valid |
| rsp_rdata | output | DW (32) | Load data |
| mem_en | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | AW (12) | Memory word address |
| mem_wdata | output | DW (32) | Memory write data |
| mem_rdata | input | DW (32) | Read data, one cycle after the read |
| busy | output | 1 | Sequence in progress |
| tx_depth | output | DEPTH_W (4) | Transaction nesting depth |
| log_ptr | output | AW (12) | Next free log word |
| rd_bits | output | NLINES (16) | Per-line transactional read bits |
| wr_bits | output | NLINES (16) | Per-line logged/written bits |

## Verification
Stores are tried outside a transaction, as a first store to a line, and as a repeat store to the same line. Comparing these separates the logged path from the in-place path by the log contents, the pointer step and the stall length. Nested begin and commit pairs show that only the outermost commit discards the log. Aborts are run with zero, one and several entries, some of which contain later overwrites. The restored memory tells a LIFO walk apart from any other order, and the order of the restore writes is compared against the logging order reversed.

// File: rtl/ulog_pkg.sv
package ulog_pkg;
  typedef enum logic [2:0] {
    OP_LOAD   = 3'd0,
    OP_STORE  = 3'd1,
    OP_BEGIN  = 3'd2,
    OP_COMMIT = 3'd3,
    OP_ABORT  = 3'd4
  } op_e;

  typedef enum logic [3:0] {
    ST_IDLE, ST_LDW, ST_LOGA, ST_LOGR, ST_LOGW, ST_STW,
    ST_ABCHK, ST_ABA, ST_ABR, ST_ABW
  } st_e;
endpackage

// File: rtl/ulog_bits.sv
module ulog_bits #(
  parameter int NLINES = 16,
  localparam int LW = $clog2(NLINES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LW-1:0]     line,
  input  logic              set_r,
  input  logic              set_w,
  input  logic              clr_all,
  output logic [NLINES-1:0] rbits,
  output logic [NLINES-1:0] wbits
);
  logic [NLINES-1:0] hit;

  for (genvar gi = 0; gi < NLINES; gi++) begin : g_dec
    assign hit[gi] = (line == LW'(gi));
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr_all) begin
      rbits <= '0;
      wbits <= '0;
    end else begin
      rbits <= rbits | (hit & {NLINES{set_r}});
      wbits <= wbits | (hit & {NLINES{set_w}});
    end
  end
endmodule

// File: rtl/ulog_ptr.sv
module ulog_ptr #(
  parameter int AW = 12,
  parameter int LOG_BASE = 512,
  parameter int ENTRY_W = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          advance,
  input  logic          retreat,
  input  logic          rewind,
  output logic [AW-1:0] ptr
);
  localparam logic [AW-1:0] BASE_A  = AW'(LOG_BASE);
  localparam logic [AW-1:0] ENTRY_A = AW'(ENTRY_W);

  always_ff @(posedge clk) begin
    if (!rst_n || rewind) ptr <= BASE_A;
    else if (advance)     ptr <= ptr + ENTRY_A;
    else if (retreat)     ptr <= ptr - ENTRY_A;
  end
endmodule

// File: rtl/ulog_ctrl.sv
module ulog_ctrl
  import ulog_pkg::*;
#(
  parameter int AW       = 12,
  parameter int DW       = 32,
  parameter int WPB      = 8,
  parameter int NLINES   = 16,
  parameter int LOG_BASE = 512,
  parameter int DEPTH_W  = 4
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   req_valid,
  output logic                                   req_ready,
  input  logic [2:0]                             req_op,
  input  logic [$clog2(NLINES)+$clog2(WPB)-1:0]  req_addr,
  input  logic [DW-1:0]                          req_wdata,
  output logic                                   rsp_valid,
  output logic [DW-1:0]                          rsp_rdata,
  output logic                                   mem_en,
  output logic                                   mem_we,
  output logic [AW-1:0]                          mem_addr,
  output logic [DW-1:0]                          mem_wdata,
  input  logic [DW-1:0]                          mem_rdata,
  output logic                                   busy,
  output logic [DEPTH_W-1:0]                     tx_depth,
  output logic [AW-1:0]                          log_ptr,
  output logic [NLINES-1:0]                      rd_bits,
  output logic [NLINES-1:0]                      wr_bits
);
  localparam int OW      = $clog2(WPB);
  localparam int LW      = $clog2(NLINES);
  localparam int ENTRY_W = 1 + WPB;
  localparam logic [AW-1:0] BASE_A  = AW'(LOG_BASE);
  localparam logic [AW-1:0] ENTRY_A = AW'(ENTRY_W);
  localparam logic [OW-1:0] K_LAST  = OW'(WPB - 1);

  st_e st, st_nx;
  logic [OW-1:0] k;
  logic [LW-1:0] sav_line, bit_line;
  logic [OW-1:0] sav_word;
  logic [DW-1:0] sav_data;
  logic [DEPTH_W-1:0] depth;
  logic accept, in_tx, ab_done;
  logic set_r, set_w, clr_all, adv, ret, rew;
  logic [LW-1:0] req_line;
  logic [AW-1:0] entry_top;

  assign req_ready = (st == ST_IDLE);
  assign busy      = ~req_ready;
  assign accept    = req_valid && req_ready;
  assign req_line  = req_addr[LW+OW-1:OW];
  assign in_tx     = (depth != '0);
  assign tx_depth  = depth;
  assign rsp_rdata = mem_rdata;
  assign bit_line  = (st == ST_IDLE) ? req_line : sav_line;
  assign entry_top = log_ptr - ENTRY_A;
  assign ab_done   = (log_ptr == BASE_A);

  ulog_bits #(.NLINES(NLINES)) u_bits (
    .clk(clk), .rst_n(rst_n), .line(bit_line), .set_r(set_r), .set_w(set_w),
    .clr_all(clr_all), .rbits(rd_bits), .wbits(wr_bits)
  );

  ulog_ptr #(.AW(AW), .LOG_BASE(LOG_BASE), .ENTRY_W(ENTRY_W)) u_ptr (
    .clk(clk), .rst_n(rst_n), .advance(adv), .retreat(ret), .rewind(rew),
    .ptr(log_ptr)
  );

  always_comb begin
    st_nx = st;
    mem_en = 1'b0; mem_we = 1'b0; mem_addr = '0; mem_wdata = '0;
    set_r = 1'b0; set_w = 1'b0; clr_all = 1'b0;
    adv = 1'b0; ret = 1'b0; rew = 1'b0; rsp_valid = 1'b0;
    unique case (st)
      ST_IDLE: if (accept) begin
        case (req_op)
          OP_LOAD: begin
            mem_en = 1'b1; mem_addr = AW'(req_addr);
            set_r = in_tx; st_nx = ST_LDW;
          end
          OP_STORE: begin
            if (in_tx && !wr_bits[req_line]) st_nx = ST_LOGA;
            else begin
              mem_en = 1'b1; mem_we = 1'b1;
              mem_addr = AW'(req_addr); mem_wdata = req_wdata;
            end
          end
          OP_COMMIT: if (depth == DEPTH_W'(1)) begin
            clr_all = 1'b1; rew = 1'b1;
          end
          OP_ABORT: if (in_tx) st_nx = ST_ABCHK;
          default: ;
        endcase
      end
      ST_LDW: begin
        rsp_valid = 1'b1; st_nx = ST_IDLE;
      end
      ST_LOGA: begin
        mem_en = 1'b1; mem_we = 1'b1; mem_addr = log_ptr;
        mem_wdata = DW'({sav_line, {OW{1'b0}}});
        st_nx = ST_LOGR;
      end
      ST_LOGR: begin
        mem_en = 1'b1; mem_addr = AW'({sav_line, k}); st_nx = ST_LOGW;
      end
      ST_LOGW: begin
        mem_en = 1'b1; mem_we = 1'b1;
        mem_addr = log_ptr + AW'(1) + AW'(k); mem_wdata = mem_rdata;
        st_nx = (k == K_LAST) ? ST_STW : ST_LOGR;
      end
      ST_STW: begin
        mem_en = 1'b1; mem_we = 1'b1;
        mem_addr = AW'({sav_line, sav_word}); mem_wdata = sav_data;
        set_w = 1'b1; adv = 1'b1; st_nx = ST_IDLE;
      end
      ST_ABCHK: begin
        if (ab_done) begin
          clr_all = 1'b1; rew = 1'b1; st_nx = ST_IDLE;
        end else begin
          mem_en = 1'b1; mem_addr = entry_top; st_nx = ST_ABA;
        end
      end
      ST_ABA: begin
        mem_en = 1'b1; mem_addr = entry_top + AW'(1); st_nx = ST_ABW;
      end
      ST_ABR: begin
        mem_en = 1'b1; mem_addr = entry_top + AW'(1) + AW'(k); st_nx = ST_ABW;
      end
      ST_ABW: begin
        mem_en = 1'b1; mem_we = 1'b1;
        mem_addr = AW'({sav_line, k}); mem_wdata = mem_rdata;
        if (k == K_LAST) begin
          ret = 1'b1; st_nx = ST_ABCHK;
        end else st_nx = ST_ABR;
      end
      default: st_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= ST_IDLE; k <= '0; depth <= '0;
      sav_line <= '0; sav_word <= '0; sav_data <= '0;
    end else begin
      st <= st_nx;
      if (accept) begin
        sav_line <= req_line;
        sav_word <= req_addr[OW-1:0];
        sav_data <= req_wdata;
        k <= '0;
        if (req_op == OP_BEGIN && depth != {DEPTH_W{1'b1}}) depth <= depth + 1'b1;
        if (req_op == OP_COMMIT && in_tx) depth <= depth - 1'b1;
      end
      if (st == ST_LOGW || st == ST_ABW) k <= (k == K_LAST) ? '0 : k + 1'b1;
      if (st == ST_ABA) sav_line <= mem_rdata[LW+OW-1:OW];
      if (st == ST_ABCHK && ab_done) depth <= '0;
    end
  end
endmodule

// File: rtl/ulog_ctrl_chk.sv
module ulog_ctrl_chk #(
  parameter int AW = 12,
  parameter int WPB = 8,
  parameter int NLINES = 16,
  parameter int LOG_BASE = 512,
  parameter int DEPTH_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [2:0]        req_op,
  input logic              rsp_valid,
  input logic              busy,
  input logic [DEPTH_W-1:0] tx_depth,
  input logic [AW-1:0]     log_ptr,
  input logic [NLINES-1:0] rd_bits,
  input logic [NLINES-1:0] wr_bits
);
  localparam logic [AW-1:0] BASE_A  = AW'(LOG_BASE);
  localparam logic [AW-1:0] ENTRY_A = AW'(1 + WPB);
  localparam logic [AW-1:0] TOP_A   = AW'(LOG_BASE + NLINES * (1 + WPB));

  // R1
  busy_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !req_ready);

  // R2
  load_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(req_valid && req_ready && req_op == 3'd0));

  // R3
  wbit_log_chk: assert property (@(posedge clk) disable iff (!rst_n)
    |(wr_bits & ~$past(wr_bits)) |-> log_ptr == $past(log_ptr) + ENTRY_A);

  // R6
  idle_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_depth == '0 |-> (rd_bits == '0 && wr_bits == '0 && log_ptr == BASE_A));

  // R3
  ptr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    log_ptr >= BASE_A && log_ptr <= TOP_A);
endmodule

bind ulog_ctrl ulog_ctrl_chk #(
  .AW(AW), .WPB(WPB), .NLINES(NLINES), .LOG_BASE(LOG_BASE), .DEPTH_W(DEPTH_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_op(req_op), .rsp_valid(rsp_valid), .busy(busy), .tx_depth(tx_depth),
  .log_ptr(log_ptr), .rd_bits(rd_bits), .wr_bits(wr_bits)
);

// File: tb/tb_ulog_ctrl.sv
module tb_ulog_ctrl;
  localparam int AW = 12, DW = 32, WPB = 8, NLINES = 16, BASE = 512, NW = WPB * NLINES;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_ready, rsp_valid, mem_en, mem_we, busy;
  logic [2:0] req_op = 0;
  logic [6:0] req_addr = 0;
  logic [DW-1:0] req_wdata = 0, rsp_rdata, mem_wdata, mem_rdata;
  logic [AW-1:0] mem_addr, log_ptr;
  logic [3:0] tx_depth;
  logic [NLINES-1:0] rd_bits, wr_bits;

  always #5 clk = ~clk;

  ulog_ctrl dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_en(mem_en),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .busy(busy), .tx_depth(tx_depth),
    .log_ptr(log_ptr), .rd_bits(rd_bits), .wr_bits(wr_bits)
  );

  logic [DW-1:0] mem_arr [0:4095];
  always @(posedge clk) if (mem_en) begin
    if (mem_we) mem_arr[mem_addr] <= mem_wdata;
    else mem_rdata <= mem_arr[mem_addr];
  end

  int checks = 0, fails = 0, busy_left = 0;
  bit done = 0, in_abort = 0;
  int exp_depth = 0, exp_ptr = BASE;
  logic [NLINES-1:0] exp_r = 0, exp_w = 0;
  logic [DW-1:0] exp_data [0:NW-1];
  logic [DW-1:0] saved [0:NW-1];
  int logq[$], restq[$];

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // ready/busy compared against the model's stall count on every clock
  always @(negedge clk) if (rst_n && !done) begin
    check(req_ready == (busy_left == 0), "R1", "req_ready", req_ready, busy_left == 0);
    if (busy_left > 0) busy_left--;
  end

  always @(posedge clk)
    if (in_abort && mem_en && mem_we && mem_addr < NW && mem_addr[2:0] == 3'd0)
      restq.push_back(int'(mem_addr) / WPB);

  task automatic compare_state(string req);
    int bad = -1;
    check(rd_bits == exp_r, req, "rd_bits", rd_bits, exp_r);
    check(wr_bits == exp_w, req, "wr_bits", wr_bits, exp_w);
    check(int'(log_ptr) == exp_ptr, req, "log_ptr", log_ptr, exp_ptr);
    check(int'(tx_depth) == exp_depth, req, "tx_depth", tx_depth, exp_depth);
    for (int i = 0; i < NW; i++) if (bad < 0 && mem_arr[i] !== exp_data[i]) bad = i;
    check(bad < 0, req, "data region", bad < 0 ? 0 : mem_arr[bad], bad < 0 ? 0 : exp_data[bad]);
  endtask

  task automatic do_op(int op, int addr, logic [DW-1:0] wd, string req);
    int line = addr / WPB, lat = 0, p0 = exp_ptr;
    bit logged = 0;
    if (op == 1 && exp_depth > 0 && !exp_w[line]) begin
      logged = 1; lat = 2 * WPB + 2;
      for (int j = 0; j < WPB; j++) saved[line*WPB+j] = exp_data[line*WPB+j];
    end
    if (op == 0) lat = 1;
    if (op == 4 && exp_depth > 0) begin
      lat = 17 * logq.size() + 1; in_abort = 1; restq.delete();
    end
    @(negedge clk);
    req_valid = 1; req_op = 3'(op); req_addr = 7'(addr); req_wdata = wd;
    @(posedge clk);
    busy_left = lat;
    @(negedge clk);
    req_valid = 0;
    if (op == 0) begin
      check(rsp_valid === 1'b1, req, "rsp_valid", rsp_valid, 1);
      check(rsp_rdata === exp_data[addr], req, "load data", rsp_rdata, exp_data[addr]);
    end
    while (busy_left > 0) @(negedge clk);
    case (op)
      0: if (exp_depth > 0) exp_r[line] = 1;
      1: begin
        if (logged) begin
          check(mem_arr[p0] == DW'(line * WPB), req, "log addr word", mem_arr[p0], line * WPB);
          for (int j = 0; j < WPB; j++)
            check(mem_arr[p0+1+j] == saved[line*WPB+j], req, "log old word",
                  mem_arr[p0+1+j], saved[line*WPB+j]);
          logq.push_back(line); exp_ptr += 1 + WPB; exp_w[line] = 1;
        end
        exp_data[addr] = wd;
      end
      2: if (exp_depth < 15) exp_depth++;
      3: if (exp_depth == 1) begin
        exp_depth = 0; exp_r = 0; exp_w = 0; exp_ptr = BASE; logq.delete();
      end else if (exp_depth > 1) exp_depth--;
      4: if (exp_depth > 0) begin
        check(restq.size() == logq.size(), "R9", "restore count", restq.size(), logq.size());
        for (int j = 0; j < logq.size() && j < restq.size(); j++)
          check(restq[j] == logq[logq.size()-1-j], "R9", "restore order",
                restq[j], logq[logq.size()-1-j]);
        foreach (logq[q])
          for (int j = 0; j < WPB; j++) exp_data[logq[q]*WPB+j] = saved[logq[q]*WPB+j];
        exp_depth = 0; exp_r = 0; exp_w = 0; exp_ptr = BASE; logq.delete();
        in_abort = 0;
      end
      default: ;
    endcase
    compare_state(req);
  endtask

  task automatic finish_run();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 4096; i++) mem_arr[i] = 32'hA500_0000 + i;
    for (int i = 0; i < NW; i++) exp_data[i] = 32'hA500_0000 + i;
    repeat (3) @(posedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check(req_ready && !busy && !rsp_valid, "R1", "reset idle", {req_ready, busy, rsp_valid}, 3'b100);
    compare_state("R1");
    // R5 store outside transaction, R2 load outside
    do_op(1, 5, 32'h1111_0005, "R5");
    do_op(0, 5, 0, "R2");
    // R7 / R10 ignored operations
    do_op(3, 0, 0, "R7");
    do_op(4, 0, 0, "R10");
    do_op(6, 3, 32'hDEAD, "R10");
    // R3, R4, R6: logging then commit
    do_op(2, 0, 0, "R6");
    do_op(0, 17, 0, "R2");
    do_op(1, 9, 32'h2222_0009, "R3");
    do_op(1, 10, 32'h2222_000A, "R4");
    do_op(1, 40, 32'h2222_0028, "R3");
    do_op(3, 0, 0, "R6");
    // R8, R9: nested, multiple entries, abort
    do_op(2, 0, 0, "R6");
    do_op(2, 0, 0, "R6");
    do_op(1, 24, 32'h3333_0018, "R3");
    do_op(1, 56, 32'h3333_0038, "R3");
    do_op(1, 3, 32'h3333_0003, "R3");
    do_op(0, 57, 0, "R2");
    do_op(3, 0, 0, "R6");
    do_op(1, 27, 32'h3333_001B, "R4");
    do_op(1, 127, 32'h3333_007F, "R3");
    do_op(4, 0, 0, "R8");
    // R8 abort with no entries
    do_op(2, 0, 0, "R6");
    do_op(0, 100, 0, "R2");
    do_op(4, 0, 0, "R8");
    // R8 single entry with repeat stores
    do_op(2, 0, 0, "R6");
    do_op(1, 9, 32'h4444_0009, "R3");
    do_op(1, 15, 32'h4444_000F, "R4");
    do_op(4, 0, 0, "R8");
    do_op(0, 9, 0, "R8");
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule